// File: doc/BRIEF.md
# I/O Recovery-Time Guard

This block sits on the bus path between a fast processor and a group of slow byte-wide peripherals. It watches every bus cycle. When an I/O cycle hits one of the guarded address windows and completes, the block starts a recovery timer for that window. While that timer runs, any further I/O cycle to the same window is held. The block does this by keeping the cycle from the downstream bus and keeping the processor's ready low. The held cycle goes through once the timer has run out.

The recovery interval for each window is a count of system clocks, supplied on an input. Integration sets it from the clock frequency and the microseconds the peripheral needs. Software can then issue back-to-back I/O instructions with no delay loops between them. Memory cycles are never stalled, and neither are I/O cycles outside the windows. Each window keeps its own timer, so recovery for one peripheral group never delays another.

Top module: `io_recovery_guard`

## Requirements
- R1: After reset no recovery is pending. The first I/O cycle to any window is forwarded in the cycle it is presented (`bus_cyc_o` = `cyc_i`).
- R2: A memory cycle (`io_i`=0) is always forwarded unchanged (`bus_cyc_o`=1 while `cyc_i`=1), even while a recovery timer runs.
- R3: An I/O cycle whose address lies in no window is forwarded unstalled, even while a recovery timer runs.
- R4: A cycle completes when `bus_cyc_o` and `bus_ack_i` are both 1. When a guarded I/O cycle completes, its window's timer loads that window's interval N from `rec_clks_i`. Guarded I/O cycles to that window are then held for the next N clock cycles and forwarded again from cycle N+1 after completion. A forwarded cycle without acknowledge starts no timer.
- R5: An interval value of 0 is treated as 1.
- R6: Each window has its own timer. A running timer in one window never holds a cycle to another window.
- R7: When windows overlap, the lowest-numbered matching window owns the access.
- R8: The interval is sampled only at the completing edge. Changing `rec_clks_i` during recovery does not alter the recovery already running.
- R9: `rdy_o` is 1 only when the cycle is forwarded and `bus_ack_i` is 1. A held cycle gets `rdy_o`=0 whatever `bus_ack_i` shows.
- R10: Window k matches when (addr & MASK_k) == (BASE_k & MASK_k). The defaults are:
  - window 0: base 0x0040, mask 0xFFF0 (addresses 0x40–0x4F);
  - window 1: base 0x0000, mask 0xFF80 (addresses 0x00–0x7F).
  - Window k's interval is `rec_clks_i[k*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_i | input | 1 | Processor bus cycle valid |
| io_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| addr_i | input | AW (16) | Cycle address |
| rec_clks_i | input | NR*CW (16) | Per-window recovery interval in clocks |
| bus_ack_i | input | 1 | Downstream acknowledge of a forwarded cycle |
| bus_cyc_o | output | 1 | Cycle forwarded to the downstream bus |
| rdy_o | output | 1 | Ready returned to the processor |

## Verification
Two things can happen in the same clock: one window's access completes and loads its timer, while the other window's timer takes its last decrement. The bench provokes this by finishing a window-1 access exactly as window 0 expires, then offering window 0 on the next cycle. A second collision pairs a completing edge with a change of `rec_clks_i`. A behavioural model, with one remaining-count integer per window, predicts `bus_cyc_o` and `rdy_o`, and both outputs are compared with it every clock.

// File: rtl/iorg_pkg.sv
package iorg_pkg;
  typedef enum logic {GATE_PASS = 1'b0, GATE_STALL = 1'b1} gate_e;

  function automatic logic win_hit(input logic [31:0] addr,
                                   input logic [31:0] base,
                                   input logic [31:0] mask);
    return ((addr & mask) == (base & mask));
  endfunction
endpackage

// File: rtl/io_win_dec.sv
module io_win_dec #(
  parameter int unsigned AW = 16,
  parameter int unsigned NR = 2,
  parameter logic [NR*AW-1:0] WIN_BASE = '0,
  parameter logic [NR*AW-1:0] WIN_MASK = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic [NR-1:0] hit_o,
  output logic [NR-1:0] sel_o
);
  import iorg_pkg::*;

  for (genvar k = 0; k < NR; k++) begin : g_win
    assign hit_o[k] = win_hit(32'(addr_i), 32'(WIN_BASE[k*AW +: AW]),
                              32'(WIN_MASK[k*AW +: AW]));
  end

  // lowest index wins on overlap
  always_comb begin
    sel_o = '0;
    for (int k = NR - 1; k >= 0; k--) begin
      if (hit_o[k]) sel_o = NR'(1) << k;
    end
  end
endmodule

// File: rtl/rec_timer.sv
module rec_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          busy_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_eff;

  assign len_eff = (len_i == '0) ? CW'(1) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_eff;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  p_load_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);
  p_zero_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && len_i == '0) |=> (cnt_q == CW'(1)));
  p_countdown_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/io_recovery_guard.sv
module io_recovery_guard #(
  parameter int unsigned AW = 16,
  parameter int unsigned NR = 2,
  parameter int unsigned CW = 8,
  parameter logic [NR*AW-1:0] WIN_BASE = {16'h0000, 16'h0040},
  parameter logic [NR*AW-1:0] WIN_MASK = {16'hFF80, 16'hFFF0}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_i,
  input  logic             io_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NR*CW-1:0] rec_clks_i,
  input  logic             bus_ack_i,
  output logic             bus_cyc_o,
  output logic             rdy_o
);
  import iorg_pkg::*;

  logic [NR-1:0] hit, sel, busy, load;
  logic          guarded;
  gate_e         gate;

  io_win_dec #(.AW(AW), .NR(NR), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  assign guarded = cyc_i && io_i && (|sel);
  assign gate    = (guarded && |(sel & busy)) ? GATE_STALL : GATE_PASS;

  assign bus_cyc_o = cyc_i && (gate == GATE_PASS);
  assign rdy_o     = bus_cyc_o && bus_ack_i;

  for (genvar k = 0; k < NR; k++) begin : g_tmr
    assign load[k] = rdy_o && io_i && sel[k];
    rec_timer #(.CW(CW)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load[k]),
      .len_i  (rec_clks_i[k*CW +: CW]),
      .busy_o (busy[k])
    );
  end

  p_mem_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && !io_i) |-> bus_cyc_o);
  p_outside_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && io_i && hit == '0) |-> bus_cyc_o);
  p_held_after_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load[0] && cyc_i && io_i && sel[0]) |=> (sel[0] && cyc_i && io_i) |-> !bus_cyc_o);
  p_sel_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  p_sel_lowest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit[0] |-> sel[0]);
  p_held_no_rdy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && !bus_cyc_o) |-> !rdy_o);
  p_one_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load));
endmodule

// File: tb/sim_io_recovery_guard.sv
module sim_io_recovery_guard;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cyc = 1'b0, io = 1'b0, ack = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] rec0 = 8'd3, rec1 = 8'd2;
  logic bus_cyc_o, rdy_o;
  int tests = 0, fails = 0;
  int rem [2];

  always #4 clk_i = ~clk_i;

  io_recovery_guard u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc), .io_i(io), .addr_i(addr),
    .rec_clks_i({rec1, rec0}), .bus_ack_i(ack),
    .bus_cyc_o(bus_cyc_o), .rdy_o(rdy_o)
  );

  function automatic int owner(input logic [15:0] a);
    if (a >= 16'h0040 && a <= 16'h004F) return 0;
    if (a <= 16'h007F) return 1;
    return -1;
  endfunction

  task automatic step(input logic c, input logic i, input logic [15:0] a,
                      input logic k, input string tag);
    int own;
    logic e_cyc, e_rdy;
    @(negedge clk_i);
    cyc = c; io = i; addr = a; ack = k;
    #1;
    own = owner(a);
    e_cyc = c && !(i && own >= 0 && rem[own] > 0);
    e_rdy = e_cyc && k;
    tests++;
    if (bus_cyc_o !== e_cyc || rdy_o !== e_rdy) begin
      fails++;
      $display("FAIL %s: bus_cyc/rdy actual %b%b expected %b%b addr %h",
               tag, bus_cyc_o, rdy_o, e_cyc, e_rdy, a);
    end
    @(posedge clk_i); #1;
    for (int w = 0; w < 2; w++) begin
      if (e_rdy && i && own == w) begin
        int v = (w == 0) ? int'(rec0) : int'(rec1);
        rem[w] = (v == 0) ? 1 : v;
      end else if (rem[w] > 0) rem[w]--;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int j = 0; j < n; j++) step(1'b0, 1'b0, 16'h0, 1'b0, tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rem[0] = 0; rem[1] = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1: first guarded access forwarded at once
    step(1'b1, 1'b1, 16'h0045, 1'b0, "R1");
    // R4: no ack, no timer; then complete and get held for rec0 cycles
    step(1'b1, 1'b1, 16'h0045, 1'b0, "R4");
    step(1'b1, 1'b1, 16'h0045, 1'b1, "R4");
    for (int j = 0; j < 5; j++) step(1'b1, 1'b1, 16'h0041, 1'b1, "R4");
    // R9: held cycle with ack high still gets no ready
    step(1'b1, 1'b1, 16'h0041, 1'b1, "R9");
    idle(4, "R4");
    // R2/R3: memory and out-of-window I/O pass during recovery
    step(1'b1, 1'b1, 16'h0040, 1'b1, "R4");
    step(1'b1, 1'b0, 16'h0040, 1'b1, "R2");
    step(1'b1, 1'b1, 16'h0090, 1'b1, "R3");
    step(1'b1, 1'b0, 16'h0044, 1'b0, "R2");
    step(1'b1, 1'b1, 16'h0080, 1'b1, "R3");
    // R6: window 1 not held by window 0's timer
    step(1'b1, 1'b1, 16'h0047, 1'b1, "R6");
    step(1'b1, 1'b1, 16'h0010, 1'b1, "R6");
    step(1'b1, 1'b1, 16'h0047, 1'b1, "R6");
    step(1'b1, 1'b1, 16'h0010, 1'b1, "R6");
    idle(5, "R6");
    // R7/R10: 0x4F belongs to window 0, 0x50 to window 1
    step(1'b1, 1'b1, 16'h004F, 1'b1, "R7");
    step(1'b1, 1'b1, 16'h0050, 1'b1, "R10");
    step(1'b1, 1'b1, 16'h0048, 1'b1, "R7");
    step(1'b1, 1'b1, 16'h007F, 1'b1, "R10");
    idle(5, "R10");
    // R5: zero interval acts as one
    rec0 = 8'd0;
    step(1'b1, 1'b1, 16'h0042, 1'b1, "R5");
    step(1'b1, 1'b1, 16'h0042, 1'b1, "R5");
    step(1'b1, 1'b1, 16'h0042, 1'b1, "R5");
    step(1'b1, 1'b1, 16'h0042, 1'b1, "R5");
    idle(2, "R5");
    // R8: interval change during recovery does not affect running one
    rec0 = 8'd6;
    step(1'b1, 1'b1, 16'h0042, 1'b1, "R8");
    rec0 = 8'd1;
    for (int j = 0; j < 8; j++) step(1'b1, 1'b1, 16'h0042, 1'b0, "R8");
    idle(2, "R8");
    // collision: window 1 completes as window 0 expires
    rec0 = 8'd3; rec1 = 8'd4;
    step(1'b1, 1'b1, 16'h0043, 1'b1, "R6");
    idle(2, "R6");
    step(1'b1, 1'b1, 16'h0020, 1'b1, "R6");
    step(1'b1, 1'b1, 16'h0043, 1'b1, "R6");
    for (int j = 0; j < 6; j++) step(1'b1, 1'b1, 16'h0020, 1'b1, "R4");
    // collision: interval change on completing edge
    idle(6, "R8");
    step(1'b1, 1'b1, 16'h0044, 1'b1, "R8");
    rec0 = 8'd2;
    for (int j = 0; j < 5; j++) step(1'b1, 1'b1, 16'h0044, 1'b1, "R8");
    // R1: reset clears pending recovery
    step(1'b1, 1'b1, 16'h0044, 1'b1, "R1");
    @(negedge clk_i); rst_ni = 1'b0; cyc = 1'b0;
    rem[0] = 0; rem[1] = 0;
    @(negedge clk_i); rst_ni = 1'b1;
    step(1'b1, 1'b1, 16'h0044, 1'b0, "R1");
    step(1'b1, 1'b1, 16'h0011, 1'b0, "R1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule